// File: doc/BRIEF.md
# Shadowed Parameter Register with Synchronized Commit

This block holds one parameter of a PWM generator, such as a falling-edge dead-band delay, as two copies. A staging copy takes every write. A live copy drives the generator. A two-bit policy field decides when the staging copy moves into the live copy. The move can happen on the write itself. It can happen at the next PWM counter-zero event. Or it can happen at the first counter-zero event that follows an explicit synchronous-update request.

The surrounding PWM generator supplies a single-cycle `cnt_zero` pulse each time its counter wraps to zero. A control block supplies a single-cycle `sync_req` pulse when software asks for a coordinated update across several generators. The live value comes straight from a register, so the generator sees a glitch-free value that only changes on a clock edge.

Top module: `shadow_update_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `active_val` equals the parameter `RESET_VAL`. No write is pending and no sync request is held.
- R2: With `upd_mode` = 0 (immediate), a write puts `wr_data` on `active_val` in the cycle after the write strobe.
- R3: `upd_mode` = 1 (reserved) behaves exactly like `upd_mode` = 0.
- R4: With `upd_mode` = 2 (local), a write leaves `active_val` unchanged and becomes pending. The pending value appears on `active_val` in the cycle after the next `cnt_zero` pulse.
- R5: Several writes before a commit overwrite the staged value. Only the last one is committed.
- R6: With `upd_mode` = 3 (global), a pending value is committed only at a `cnt_zero` pulse seen after a `sync_req` pulse in an earlier cycle. A `cnt_zero` with no held request leaves `active_val` unchanged.
- R7: A held sync request is dropped at the next `cnt_zero` pulse, whether or not anything was pending. A later write in mode 3 needs a fresh request.
- R8: When a write and a `cnt_zero` pulse fall in the same cycle, the commit takes the value that was pending before that write. The new write stays pending for the next eligible `cnt_zero`.
- R9: A `sync_req` in the same cycle as `cnt_zero` does not enable that `cnt_zero`. It is held for the next one.
- R10: `active_val` changes only on a clock edge that samples either a write in mode 0 or 1, or a `cnt_zero` pulse with a value pending.
- R11: A `cnt_zero` pulse with nothing pending leaves `active_val` unchanged.
- R12: A write in mode 0 or 1 discards any value still pending from an earlier deferred write, so a later `cnt_zero` does not overwrite it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the staged value |
| wr_data | input | DATA_W | Write data |
| upd_mode | input | 2 | Commit policy: 0 immediate, 1 reserved (as 0), 2 local, 3 global |
| cnt_zero | input | 1 | One-cycle pulse when the PWM counter reaches zero |
| sync_req | input | 1 | One-cycle synchronous-update request |
| active_val | output | DATA_W | Live value used by the generator |

## Verification
Immediate writes in modes 0 and 1 check that the live value follows the bus with one register of delay. Mode 2 sequences check deferral: a lone write, several writes before one zero, and a write that lands on the zero. Together they show that the commit takes the old staged value and that last-write-wins holds. Mode 3 sequences separate three cases: a zero with no request held, a request dropped against an empty stage, and a request that coincides with a zero. These show the request is sticky, single-use and only counts when it arrives earlier. A final random phase mixes all modes, strobes and pulses against a reference model, which exposes any spurious change of the live value.

// File: rtl/sync_upd_pkg.sv
package sync_upd_pkg;

  typedef enum logic [1:0] {
    UPD_IMMEDIATE = 2'd0,
    UPD_RESERVED  = 2'd1,
    UPD_LOCAL     = 2'd2,
    UPD_GLOBAL    = 2'd3
  } upd_mode_e;

  // direct: write goes straight to the live copy
  // need_sync: commit at zero also needs a held sync request
  typedef struct packed {
    logic direct;
    logic need_sync;
  } upd_policy_t;

endpackage

// File: rtl/upd_mode_decode.sv
module upd_mode_decode
  import sync_upd_pkg::*;
#(
  parameter bit RSVD_AS_IMM = 1'b1
) (
  input  logic [1:0]  mode_i,
  output upd_policy_t policy_o
);

  upd_mode_e mode_e;
  logic      rsvd_direct;

  assign mode_e = upd_mode_e'(mode_i);

  // The spare encoding gets a defined meaning chosen at build time.
  generate
    if (RSVD_AS_IMM) begin : g_rsvd_imm
      assign rsvd_direct = 1'b1;
    end else begin : g_rsvd_local
      assign rsvd_direct = 1'b0;
    end
  endgenerate

  always_comb begin
    policy_o = '0;
    unique case (mode_e)
      UPD_IMMEDIATE: policy_o.direct = 1'b1;
      UPD_RESERVED:  policy_o.direct = rsvd_direct;
      UPD_LOCAL:     policy_o.direct = 1'b0;
      UPD_GLOBAL:    policy_o.need_sync = 1'b1;
      default:       policy_o = '0;
    endcase
  end

endmodule

// File: rtl/upd_sync_tracker.sv
module upd_sync_tracker (
  input  logic clk,
  input  logic rst,
  input  logic sync_req_i,
  input  logic cnt_zero_i,
  output logic flag_o
);

  logic flag_q;

  // A request is sticky until the next zero consumes or drops it.
  // A request seen in the same cycle as a zero survives that zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (sync_req_i) begin
      flag_q <= 1'b1;
    end else if (cnt_zero_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  p_req_latched_r9: assert property (@(posedge clk) disable iff (rst)
    sync_req_i |=> flag_q);

  p_zero_drops_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt_zero_i && !sync_req_i) |=> !flag_q);

endmodule

// File: rtl/upd_shadow_reg.sv
module upd_shadow_reg #(
  parameter int unsigned           DATA_W    = 16,
  parameter logic [DATA_W-1:0]     RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              direct_i,
  input  logic              commit_ok_i,
  output logic [DATA_W-1:0] active_o,
  output logic              pending_o
);

  logic [DATA_W-1:0] stage_q;
  logic [DATA_W-1:0] active_q;
  logic              pend_q;
  logic              do_commit;

  assign do_commit = commit_ok_i && pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q  <= RESET_VAL;
      active_q <= RESET_VAL;
      pend_q   <= 1'b0;
    end else if (wr_en_i && direct_i) begin
      stage_q  <= wr_data_i;
      active_q <= wr_data_i;
      pend_q   <= 1'b0;
    end else begin
      if (do_commit) begin
        active_q <= stage_q;
        pend_q   <= 1'b0;
      end
      if (wr_en_i) begin
        stage_q <= wr_data_i;
        pend_q  <= 1'b1;
      end
    end
  end

  assign active_o  = active_q;
  assign pending_o = pend_q;

  p_direct_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && direct_i) |=> (active_q == $past(wr_data_i)) && !pend_q);

  p_deferred_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !direct_i && !commit_ok_i) |=> $stable(active_q) && pend_q);

  p_overlap_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !direct_i && commit_ok_i) |=> pend_q);

  p_quiet_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && !commit_ok_i) |=> $stable(active_q));

  p_empty_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && !pend_q) |=> $stable(active_q) && !pend_q);

endmodule

// File: rtl/shadow_update_ctrl.sv
module shadow_update_ctrl
  import sync_upd_pkg::*;
#(
  parameter int unsigned       DATA_W      = 16,
  parameter logic [DATA_W-1:0] RESET_VAL   = '0,
  parameter bit                RSVD_AS_IMM = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        upd_mode,
  input  logic              cnt_zero,
  input  logic              sync_req,
  output logic [DATA_W-1:0] active_val
);

  upd_policy_t policy;
  logic        sync_flag;
  logic        commit_ok;
  logic        pending;

  upd_mode_decode #(
    .RSVD_AS_IMM(RSVD_AS_IMM)
  ) u_decode (
    .mode_i  (upd_mode),
    .policy_o(policy)
  );

  upd_sync_tracker u_sync (
    .clk       (clk),
    .rst       (rst),
    .sync_req_i(sync_req),
    .cnt_zero_i(cnt_zero),
    .flag_o    (sync_flag)
  );

  // Zero is the only commit point; global policy also needs a held request.
  assign commit_ok = cnt_zero && (!policy.need_sync || sync_flag);

  upd_shadow_reg #(
    .DATA_W   (DATA_W),
    .RESET_VAL(RESET_VAL)
  ) u_shadow (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .direct_i   (policy.direct),
    .commit_ok_i(commit_ok),
    .active_o   (active_val),
    .pending_o  (pending)
  );

  p_global_waits_r6: assert property (@(posedge clk) disable iff (rst)
    (upd_mode == 2'd3 && !sync_flag && !wr_en) |=> $stable(active_val));

  p_reserved_direct_r3: assert property (@(posedge clk) disable iff (rst)
    (RSVD_AS_IMM && upd_mode == 2'd1 && wr_en) |=> (active_val == $past(wr_data)));

  p_direct_clears_r12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && upd_mode == 2'd0) |=> !pending);

endmodule

// File: tb/shadow_update_ctrl_tb_top.sv
module shadow_update_ctrl_tb_top;

  localparam int unsigned       DW   = 16;
  localparam logic [DW-1:0]     RVAL = 16'h00A5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    upd_mode = 2'd0;
  logic          cnt_zero = 1'b0;
  logic          sync_req = 1'b0;
  logic [DW-1:0] active_val;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [DW-1:0] val;
    string         tag;
  } exp_t;
  exp_t sb_q[$];

  // reference state derived from the requirements
  logic [DW-1:0] m_active = RVAL;
  logic [DW-1:0] m_stage  = RVAL;
  bit            m_pend   = 1'b0;
  bit            m_flag   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  shadow_update_ctrl #(.DATA_W(DW), .RESET_VAL(RVAL)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .upd_mode(upd_mode), .cnt_zero(cnt_zero), .sync_req(sync_req),
    .active_val(active_val)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: active_val=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected result
  task automatic step(input bit w, input logic [DW-1:0] d, input logic [1:0] m,
                      input bit cz, input bit sr, input string tag);
    exp_t e;
    bit   commit;
    @(negedge clk);
    wr_en = w; wr_data = d; upd_mode = m; cnt_zero = cz; sync_req = sr;
    commit = cz && m_pend && (m != 2'd3 || m_flag);
    if (w && m <= 2'd1) begin
      m_active = d; m_stage = d; m_pend = 1'b0;
    end else begin
      if (commit) begin m_active = m_stage; m_pend = 1'b0; end
      if (w) begin m_stage = d; m_pend = 1'b1; end
    end
    if (sr) m_flag = 1'b1;
    else if (cz) m_flag = 1'b0;
    e.val = m_active; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare after each edge that has an expected item
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, active_val, e.val);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: active_val=%h expected=completion", active_val);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset value
    repeat (3) @(negedge clk);
    check("R1", active_val, RVAL);
    @(negedge clk);
    rst = 1'b0;
    #1 check("R1", active_val, RVAL);

    // R2: immediate
    step(1, 16'h0011, 2'd0, 0, 0, "R2");
    step(0, 16'h0000, 2'd0, 0, 0, "R2");
    // R3: reserved acts as immediate
    step(1, 16'h0022, 2'd1, 0, 0, "R3");
    // R4: local waits for zero
    step(1, 16'h0033, 2'd2, 0, 0, "R4");
    step(0, 16'h0000, 2'd2, 0, 0, "R4");
    step(0, 16'h0000, 2'd2, 1, 0, "R4");
    // R11: zero with nothing pending
    step(0, 16'h0000, 2'd2, 1, 0, "R11");
    // R5: last write wins
    step(1, 16'h0044, 2'd2, 0, 0, "R5");
    step(1, 16'h0055, 2'd2, 0, 0, "R5");
    step(0, 16'h0000, 2'd2, 1, 0, "R5");
    // R8: write on the zero
    step(1, 16'h0066, 2'd2, 0, 0, "R8");
    step(1, 16'h0077, 2'd2, 1, 0, "R8");
    step(0, 16'h0000, 2'd2, 0, 0, "R8");
    step(0, 16'h0000, 2'd2, 1, 0, "R8");
    // R6: global needs an earlier request
    step(1, 16'h0088, 2'd3, 0, 0, "R6");
    step(0, 16'h0000, 2'd3, 1, 0, "R6");
    step(0, 16'h0000, 2'd3, 0, 1, "R6");
    step(0, 16'h0000, 2'd3, 0, 0, "R6");
    step(0, 16'h0000, 2'd3, 1, 0, "R6");
    // R7: request dropped against an empty stage
    step(0, 16'h0000, 2'd3, 0, 1, "R7");
    step(0, 16'h0000, 2'd3, 1, 0, "R7");
    step(1, 16'h0099, 2'd3, 0, 0, "R7");
    step(0, 16'h0000, 2'd3, 1, 0, "R7");
    step(0, 16'h0000, 2'd3, 0, 1, "R7");
    step(0, 16'h0000, 2'd3, 1, 0, "R7");
    // R9: request coinciding with zero counts only for the next zero
    step(1, 16'h00AA, 2'd3, 0, 0, "R9");
    step(0, 16'h0000, 2'd3, 1, 1, "R9");
    step(0, 16'h0000, 2'd3, 0, 0, "R9");
    step(0, 16'h0000, 2'd3, 1, 0, "R9");
    // R12: immediate write discards a stale pending value
    step(1, 16'h00BB, 2'd2, 0, 0, "R12");
    step(1, 16'h00CC, 2'd0, 0, 0, "R12");
    step(0, 16'h0000, 2'd2, 1, 0, "R12");
    // R10: random mix against the model
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 4) == 0, DW'($urandom), 2'($urandom),
           ($urandom % 5) == 0, ($urandom % 6) == 0, "R10");
    end
    step(0, 16'h0000, 2'd0, 0, 0, "R10");
    @(posedge clk);
    #5;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule